// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate with Sticky Timeout

This block sits behind the byte-wide register window of a parallel port and turns host accesses into peripheral-side byte handshakes. A host access at offset 3 becomes an address-phase transfer and an access at offset 4 becomes a data-phase transfer. Data-phase accesses may be one, two or four bytes wide; the block splits wider accesses into single-byte handshakes, lowest byte first, and reassembles read bytes in the same order.

A transfer starts only when the control shadow holds the one bit pattern that allows it. Reads and writes each have their own pattern. Any other pattern turns the access into a no-op that completes at once. Each byte handshake raises a request and waits for a done or error pulse from the peripheral. A peripheral error ends the access and sets a sticky timeout flag, and so does silence that lasts longer than a parameterised limit. Status reads carry this flag in bit 0. Writing a one to bit 0 of the status offset clears it.

The host raises a one-cycle request. The block answers with a one-cycle acknowledge that carries the read word, and it holds a busy output while a transfer is in progress.

Top module: `epp_cycle_gate`

## Requirements
- R1: Offset 3 runs a single address-phase byte handshake (periIsAddr = 1) and offset 4 runs data-phase handshakes (periIsAddr = 0). Offset 3 always uses a one-byte width, whatever hostSize says.
- R2: A write at offset 3 or 4 runs only when control bits {5 direction, 3 select, 2 init, 1 autofeed, 0 strobe} equal init = 1 with the others 0 (control & 0x2F == 0x04). Bits 4, 7 and 6 do not matter. Otherwise no request is raised.
- R3: A read at offset 3 or 4 runs only when control & 0x2F == 0x24 (direction = 1 and init = 1). Otherwise no request is raised.
- R4: An access that is gated off is acknowledged one cycle after it is accepted. A read that is gated off, or that fails, returns all ones at the access width: hostSize 0 gives 0xFF, 1 gives 0xFFFF, 2 gives 0xFFFFFFFF. Write acknowledges also carry all ones at the access width.
- R5: An access of N bytes runs N handshakes, least significant byte first, with one idle cycle between them. A read assembles byte k of the result from handshake k.
- R6: A periErr pulse, or TMO_CYCLES request cycles with no response, ends the access, sets the sticky timeout flag and stops any remaining bytes.
- R7: A write to offset 1 with data bit 0 = 1 clears the timeout flag. The same write with bit 0 = 0 leaves the flag unchanged.
- R8: A read at offset 1 returns {extStatus[7:1], timeout flag}, zero-extended.
- R9: After reset the timeout flag is 0, the control shadow is 0xCC, busy is low and no request is raised.
- R10: hostBusy is high from the cycle after an accepted transfer until the acknowledge cycle. The acknowledge comes N*(L+2) cycles after acceptance, where L is the peripheral's wait in cycles before it answers each byte.
- R11: A write to offset 2 stores the data byte with bits 7:6 forced to 1. A read at offset 2 returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | One-cycle access request; taken only while hostBusy is low |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 3 | Register offset |
| hostSize | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read word, valid while hostAck is high |
| hostAck | output | 1 | One-cycle completion pulse |
| hostBusy | output | 1 | Transfer in progress |
| extStatus | input | 8 | Status byte from the port lines |
| ctrlPins | output | 8 | Current control shadow |
| periReq | output | 1 | Byte handshake request |
| periIsAddr | output | 1 | Current handshake is address phase |
| periWr | output | 1 | Current handshake is a write |
| periWdata | output | 8 | Byte to write |
| periRdata | input | 8 | Byte read from peripheral |
| periDone | input | 1 | Byte handshake finished |
| periErr | input | 1 | Byte handshake failed |

## Verification
A request is taken at a clock edge. Register accesses and gated-off accesses acknowledge one cycle later. A transfer of N bytes with peripheral wait L acknowledges N*(L+2) cycles later. A failure on byte k acknowledges after the cycles used up to that byte. A silent peripheral acknowledges TMO_CYCLES+1 cycles after acceptance. The bench drives each request at a falling edge and then counts falling edges until it sees the acknowledge, so every sample falls half a period away from the edge that produced it. It compares that count with the latency it computes for the access, then reads the word, the handshake count and the logged bytes from its own peripheral model.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam int HOST_LANES = 4;
  localparam int LANE_W     = $clog2(HOST_LANES);
  localparam int HOST_W     = 8 * HOST_LANES;
  localparam int SIZE_W     = 2;

  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;
  localparam logic [2:0] OFS_EADDR  = 3'd3;
  localparam logic [2:0] OFS_EDATA  = 3'd4;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTRL_FIXED = 8'hC0;
  localparam logic [7:0] CTRL_RESET = 8'hCC;

  typedef enum logic [1:0] {RSP_ONES, RSP_CTRL, RSP_STAT, RSP_EPP} rsp_e;

  typedef struct packed {
    logic              ctrlLoad;
    logic              tmoClear;
    logic              tmoSet;
    logic              bufLoad;
    logic              byteCap;
    logic [LANE_W-1:0] byteSel;
    logic              ackLoad;
    rsp_e              rspSel;
    logic [SIZE_W-1:0] rspSize;
  } dp_stb_t;
endpackage

// File: rtl/epp_gate_ctrl.sv
module epp_gate_ctrl
  import epp_gate_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [2:0]        hostAddr,
  input  logic [SIZE_W-1:0] hostSize,
  input  logic              hostWd0,
  input  logic [7:0]        ctrlShadow,
  input  logic              periDone,
  input  logic              periErr,
  output logic              periReq,
  output logic              periIsAddr,
  output logic              periWr,
  output logic              hostBusy,
  output dp_stb_t           stb
);
  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} state_e;

  state_e            state, stateNext;
  logic [LANE_W-1:0] laneIdx, lastLane;
  logic [CNT_W-1:0]  waitCnt;
  logic [SIZE_W-1:0] sizeQ;
  logic              wrQ, isAddrQ;

  logic              isEpp, gateOk, timedOut, xferFail;
  logic [SIZE_W-1:0] effSize;
  logic [7:0]        gatePat;

  function automatic logic [LANE_W-1:0] lastOf(input logic [SIZE_W-1:0] s);
    return LANE_W'((1 << s) - 1);
  endfunction

  always_comb begin
    isEpp    = (hostAddr == OFS_EADDR) || (hostAddr == OFS_EDATA);
    if (hostAddr == OFS_EADDR)      effSize = '0;
    else if (hostSize > SIZE_W'(2)) effSize = SIZE_W'(2);
    else                            effSize = hostSize;
    gatePat  = ctrlShadow & GATE_MASK;
    gateOk   = hostWr ? (gatePat == GATE_WR) : (gatePat == GATE_RD);
    timedOut = (waitCnt == CNT_LAST);
    xferFail = periErr || (!periDone && timedOut);
  end

  always_comb begin
    stb         = '0;
    stb.rspSel  = RSP_ONES;
    stb.rspSize = sizeQ;
    stb.byteSel = laneIdx;
    stateNext   = state;
    unique case (state)
      ST_IDLE: begin
        if (hostReq) begin
          if (isEpp && gateOk) begin
            stb.bufLoad = 1'b1;
            stateNext   = ST_XFER;
          end else begin
            stb.ackLoad  = 1'b1;
            stb.rspSize  = effSize;
            stb.ctrlLoad = hostWr && (hostAddr == OFS_CTRL);
            stb.tmoClear = hostWr && (hostAddr == OFS_STATUS) && hostWd0;
            if (!hostWr && hostAddr == OFS_STATUS)    stb.rspSel = RSP_STAT;
            else if (!hostWr && hostAddr == OFS_CTRL) stb.rspSel = RSP_CTRL;
            else                                      stb.rspSel = RSP_ONES;
          end
        end
      end
      ST_XFER: begin
        if (xferFail) begin
          stb.tmoSet  = 1'b1;
          stb.ackLoad = 1'b1;
          stb.rspSel  = RSP_ONES;
          stateNext   = ST_IDLE;
        end else if (periDone) begin
          stb.byteCap = 1'b1;
          if (laneIdx == lastLane) begin
            stb.ackLoad = 1'b1;
            stb.rspSel  = wrQ ? RSP_ONES : RSP_EPP;
            stateNext   = ST_IDLE;
          end else begin
            stateNext = ST_GAP;
          end
        end
      end
      ST_GAP:  stateNext = ST_XFER;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      laneIdx  <= '0;
      lastLane <= '0;
      waitCnt  <= '0;
      sizeQ    <= '0;
      wrQ      <= 1'b0;
      isAddrQ  <= 1'b0;
    end else begin
      state <= stateNext;
      unique case (state)
        ST_IDLE: begin
          if (hostReq && isEpp && gateOk) begin
            laneIdx  <= '0;
            lastLane <= lastOf(effSize);
            sizeQ    <= effSize;
            wrQ      <= hostWr;
            isAddrQ  <= (hostAddr == OFS_EADDR);
            waitCnt  <= '0;
          end
        end
        ST_XFER: begin
          if (!xferFail && periDone) begin
            laneIdx <= laneIdx + 1'b1;
            waitCnt <= '0;
          end else if (!xferFail) begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: waitCnt <= '0;
      endcase
    end
  end

  assign periReq    = (state == ST_XFER);
  assign periIsAddr = isAddrQ;
  assign periWr     = wrQ;
  assign hostBusy   = (state != ST_IDLE);
endmodule

// File: rtl/epp_gate_dpath.sv
module epp_gate_dpath
  import epp_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_stb_t           stb,
  input  logic [HOST_W-1:0] hostWdata,
  input  logic [7:0]        extStatus,
  input  logic [7:0]        periRdata,
  output logic [7:0]        ctrlShadow,
  output logic              tmoFlag,
  output logic [7:0]        periWdata,
  output logic [HOST_W-1:0] hostRdata,
  output logic              hostAck
);
  logic [7:0]        ctrlQ;
  logic              tmoQ;
  logic [HOST_W-1:0] wrBuf, rdBuf, rdNext, rspWord, rdataQ;
  logic              ackQ;

  function automatic logic [HOST_W-1:0] onesAt(input logic [SIZE_W-1:0] s);
    logic [HOST_W-1:0] m;
    m = '0;
    for (int b = 0; b < HOST_LANES; b++)
      if (b < (1 << s)) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  for (genvar g = 0; g < HOST_LANES; g++) begin : g_lane
    assign rdNext[8*g +: 8] = (stb.byteCap && stb.byteSel == LANE_W'(g))
                              ? periRdata : rdBuf[8*g +: 8];
  end

  always_comb begin
    unique case (stb.rspSel)
      RSP_CTRL: rspWord = {{(HOST_W-8){1'b0}}, ctrlQ};
      RSP_STAT: rspWord = {{(HOST_W-8){1'b0}}, extStatus[7:1], tmoQ};
      RSP_EPP:  rspWord = rdNext & onesAt(stb.rspSize);
      default:  rspWord = onesAt(stb.rspSize);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= CTRL_RESET;
      tmoQ   <= 1'b0;
      wrBuf  <= '0;
      rdBuf  <= '1;
      rdataQ <= '0;
      ackQ   <= 1'b0;
    end else begin
      if (stb.ctrlLoad) ctrlQ <= hostWdata[7:0] | CTRL_FIXED;
      if (stb.tmoSet)        tmoQ <= 1'b1;
      else if (stb.tmoClear) tmoQ <= 1'b0;
      if (stb.bufLoad) begin
        wrBuf <= hostWdata;
        rdBuf <= '1;
      end else if (stb.byteCap) begin
        rdBuf <= rdNext;
      end
      ackQ <= stb.ackLoad;
      if (stb.ackLoad) rdataQ <= rspWord;
    end
  end

  assign ctrlShadow = ctrlQ;
  assign tmoFlag    = tmoQ;
  assign periWdata  = wrBuf[8*stb.byteSel +: 8];
  assign hostRdata  = rdataQ;
  assign hostAck    = ackQ;
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [2:0]        hostAddr,
  input  logic [SIZE_W-1:0] hostSize,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  output logic              hostAck,
  output logic              hostBusy,
  input  logic [7:0]        extStatus,
  output logic [7:0]        ctrlPins,
  output logic              periReq,
  output logic              periIsAddr,
  output logic              periWr,
  output logic [7:0]        periWdata,
  input  logic [7:0]        periRdata,
  input  logic              periDone,
  input  logic              periErr
);
  dp_stb_t    stb;
  logic [7:0] ctrlShadow;
  logic       tmoFlag;

  epp_gate_ctrl #(.TMO_CYCLES(TMO_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostReq    (hostReq),
    .hostWr     (hostWr),
    .hostAddr   (hostAddr),
    .hostSize   (hostSize),
    .hostWd0    (hostWdata[0]),
    .ctrlShadow (ctrlShadow),
    .periDone   (periDone),
    .periErr    (periErr),
    .periReq    (periReq),
    .periIsAddr (periIsAddr),
    .periWr     (periWr),
    .hostBusy   (hostBusy),
    .stb        (stb)
  );

  epp_gate_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostWdata  (hostWdata),
    .extStatus  (extStatus),
    .periRdata  (periRdata),
    .ctrlShadow (ctrlShadow),
    .tmoFlag    (tmoFlag),
    .periWdata  (periWdata),
    .hostRdata  (hostRdata),
    .hostAck    (hostAck)
  );

  assign ctrlPins = ctrlShadow;
endmodule

// File: rtl/epp_gate_chk.sv
module epp_gate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostReq,
  input logic       hostWr,
  input logic [2:0] hostAddr,
  input logic       hostWd0,
  input logic       hostBusy,
  input logic       hostAck,
  input logic       periReq,
  input logic       periErr,
  input logic       tmoFlag,
  input logic [7:0] ctrlShadow
);
  p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    periReq |-> hostBusy);

  p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> !hostBusy);

  p_err_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (periReq && periErr) |=> tmoFlag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tmoFlag && !(hostReq && !hostBusy && hostWr && hostAddr == 3'd1 && hostWd0))
    |=> tmoFlag);

  p_gate_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostBusy && hostWr && (hostAddr == 3'd3 || hostAddr == 3'd4)
     && ((ctrlShadow & 8'h2F) != 8'h04)) |=> !hostBusy);

  p_gate_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostBusy && !hostWr && (hostAddr == 3'd3 || hostAddr == 3'd4)
     && ((ctrlShadow & 8'h2F) != 8'h24)) |=> !hostBusy);
endmodule

bind epp_cycle_gate epp_gate_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostReq    (hostReq),
  .hostWr     (hostWr),
  .hostAddr   (hostAddr),
  .hostWd0    (hostWdata[0]),
  .hostBusy   (hostBusy),
  .hostAck    (hostAck),
  .periReq    (periReq),
  .periErr    (periErr),
  .tmoFlag    (tmoFlag),
  .ctrlShadow (ctrlShadow)
);

// File: tb/sim_epp_cycle_gate.sv
module sim_epp_cycle_gate;
  localparam real HALF = 2.5;
  localparam int  TMO  = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWr = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostAck, hostBusy;
  logic [7:0]  extStatus = 8'h5F;
  logic [7:0]  ctrlPins;
  logic        periReq, periIsAddr, periWr;
  logic [7:0]  periWdata, periRdata;
  logic        periDone, periErr;

  int checks = 0, fails = 0;

  // peripheral model
  logic [31:0] rdWord = 32'hA1B2C3D4;
  logic [3:0]  waitC;
  logic [1:0]  byteNo;
  logic [2:0]  errLane = 3'd4;
  logic [1:0]  lat = 2'd0;
  logic        hang = 1'b0, pmClr = 1'b0, expAddr = 1'b0, addrBad;
  logic [7:0]  wlog [4];
  int          nHs;

  always #(HALF * 1ns) clk = ~clk;

  epp_cycle_gate #(.TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostAck(hostAck), .hostBusy(hostBusy),
    .extStatus(extStatus), .ctrlPins(ctrlPins), .periReq(periReq),
    .periIsAddr(periIsAddr), .periWr(periWr), .periWdata(periWdata),
    .periRdata(periRdata), .periDone(periDone), .periErr(periErr));

  wire respond = periReq && !hang && (waitC == {2'b00, lat});
  assign periDone  = respond && ({1'b0, byteNo} != errLane);
  assign periErr   = respond && ({1'b0, byteNo} == errLane);
  assign periRdata = rdWord[8*byteNo +: 8];

  always_ff @(posedge clk) begin
    if (pmClr) begin
      waitC <= '0; byteNo <= '0; nHs <= 0; addrBad <= 1'b0;
    end else if (!periReq) begin
      waitC <= '0;
    end else if (periDone || periErr) begin
      waitC <= '0;
      nHs   <= nHs + 1;
      if (periIsAddr != expAddr) addrBad <= 1'b1;
      if (periDone) begin
        if (periWr) wlog[byteNo] <= periWdata;
        byteNo <= byteNo + 1'b1;
      end
    end else begin
      waitC <= waitC + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [2:0] addr, input logic [1:0] size,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int cyc, output bit busyOk);
    @(negedge clk);
    hostReq = 1'b1; hostWr = wr; hostAddr = addr; hostSize = size; hostWdata = wd;
    pmClr = 1'b1; expAddr = (addr == 3'd3);
    @(negedge clk);
    hostReq = 1'b0; pmClr = 1'b0;
    cyc = 1; busyOk = 1'b1;
    while (!hostAck && cyc < 400) begin
      if (!hostBusy) busyOk = 1'b0;
      @(negedge clk);
      cyc++;
    end
    rd = hostRdata;
  endtask

  task automatic pulseReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  typedef struct packed {
    logic [7:0]  ctl;
    logic        wr;
    logic [2:0]  addr;
    logic [1:0]  size;
    logic [1:0]  lt;
    logic [2:0]  nb;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h04, 1'b1, 3'd4, 2'd0, 2'd0, 3'd1, 32'h0000005A, 32'h000000FF},
    '{8'h04, 1'b1, 3'd4, 2'd1, 2'd1, 3'd2, 32'h00001234, 32'h0000FFFF},
    '{8'h04, 1'b1, 3'd4, 2'd2, 2'd0, 3'd4, 32'hDEADBEEF, 32'hFFFFFFFF},
    '{8'h04, 1'b1, 3'd3, 2'd0, 2'd2, 3'd1, 32'h00000077, 32'h000000FF},
    '{8'h24, 1'b0, 3'd4, 2'd0, 2'd0, 3'd1, 32'h0,        32'h000000D4},
    '{8'h24, 1'b0, 3'd4, 2'd1, 2'd1, 3'd2, 32'h0,        32'h0000C3D4},
    '{8'h24, 1'b0, 3'd4, 2'd2, 2'd0, 3'd4, 32'h0,        32'hA1B2C3D4},
    '{8'h24, 1'b0, 3'd3, 2'd0, 2'd1, 3'd1, 32'h0,        32'h000000D4},
    '{8'h14, 1'b1, 3'd4, 2'd0, 2'd0, 3'd1, 32'h00000099, 32'h000000FF},
    '{8'h05, 1'b1, 3'd4, 2'd0, 2'd0, 3'd0, 32'h0000005A, 32'h000000FF},
    '{8'h24, 1'b1, 3'd4, 2'd1, 2'd0, 3'd0, 32'h00001111, 32'h0000FFFF},
    '{8'h04, 1'b0, 3'd4, 2'd2, 2'd0, 3'd0, 32'h0,        32'hFFFFFFFF},
    '{8'h0C, 1'b0, 3'd3, 2'd0, 2'd0, 3'd0, 32'h0,        32'h000000FF},
    '{8'h26, 1'b0, 3'd4, 2'd0, 2'd0, 3'd0, 32'h0,        32'h000000FF},
    '{8'h00, 1'b1, 3'd3, 2'd2, 2'd0, 3'd0, 32'h0,        32'h000000FF},
    '{8'h34, 1'b0, 3'd3, 2'd2, 2'd0, 3'd1, 32'h0,        32'h000000D4}
  };

  initial begin
    #(HALF * 2 * 150000 * 1ns);
    fails++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    bit bok;
    pmClr = 1'b1;
    repeat (3) @(negedge clk);
    pmClr = 1'b0;
    rstN = 1'b1;

    // R9: reset state
    chk(!hostBusy && !periReq, "R9 idle after reset", {hostBusy, periReq}, 0);
    access(1'b0, 3'd2, 2'd0, 0, rd, cyc, bok);
    chk(rd == 32'hCC, "R9 control reset value", rd, 32'hCC);
    access(1'b0, 3'd1, 2'd0, 0, rd, cyc, bok);
    chk(rd == 32'h5E, "R9 R8 status with flag clear", rd, 32'h5E);
    access(1'b1, 3'd4, 2'd0, 32'h42, rd, cyc, bok);
    chk(nHs == 0 && cyc == 1, "R2 gated by reset control", nHs, 0);

    // R11: control write forces top bits
    access(1'b1, 3'd2, 2'd0, 32'h3A, rd, cyc, bok);
    chk(cyc == 1, "R11 control write latency", cyc, 1);
    access(1'b0, 3'd2, 2'd0, 0, rd, cyc, bok);
    chk(rd == 32'hFA, "R11 control readback", rd, 32'hFA);

    // vector table
    for (int i = 0; i < NV; i++) begin
      int expCyc;
      access(1'b1, 3'd2, 2'd0, {24'h0, VEC[i].ctl}, rd, cyc, bok);
      lat = VEC[i].lt; hang = 1'b0; errLane = 3'd4;
      access(VEC[i].wr, VEC[i].addr, VEC[i].size, VEC[i].wd, rd, cyc, bok);
      expCyc = (VEC[i].nb == 0) ? 1 : int'(VEC[i].nb) * (int'(VEC[i].lt) + 2);
      chk(cyc == expCyc, VEC[i].nb == 0 ? "R4 gated ack latency" : "R10 ack latency", cyc, expCyc);
      chk(rd == VEC[i].exp, VEC[i].nb == 0 ? "R4 all-ones response" : "R5 assembled word", rd, VEC[i].exp);
      chk(nHs == int'(VEC[i].nb), VEC[i].wr ? "R2 write gate handshakes" : "R3 read gate handshakes", nHs, VEC[i].nb);
      chk(!addrBad, "R1 address phase flag", addrBad, 0);
      if (VEC[i].nb != 0) chk(bok, "R10 busy held", bok, 1);
      if (VEC[i].wr) begin
        for (int b = 0; b < int'(VEC[i].nb); b++)
          chk(wlog[b] == VEC[i].wd[8*b +: 8], "R5 byte order", wlog[b], VEC[i].wd[8*b +: 8]);
      end
    end

    // R6: error on second byte of a 4-byte read
    access(1'b1, 3'd2, 2'd0, 32'h24, rd, cyc, bok);
    lat = 2'd0; errLane = 3'd1;
    access(1'b0, 3'd4, 2'd2, 0, rd, cyc, bok);
    chk(rd == 32'hFFFFFFFF, "R6 failed read returns ones", rd, 32'hFFFFFFFF);
    chk(nHs == 2, "R6 stops at failing byte", nHs, 2);
    chk(cyc == 4, "R6 error ack latency", cyc, 4);
    errLane = 3'd4;
    access(1'b0, 3'd1, 2'd0, 0, rd, cyc, bok);
    chk(rd == 32'h5F, "R6 flag set after error", rd, 32'h5F);
    extStatus = 8'h5E;
    access(1'b0, 3'd1, 2'd0, 0, rd, cyc, bok);
    chk(rd == 32'h5F, "R8 bit0 replaced by flag", rd, 32'h5F);

    // R7: clear behaviour
    access(1'b1, 3'd1, 2'd0, 32'hFE, rd, cyc, bok);
    access(1'b0, 3'd1, 2'd0, 0, rd, cyc, bok);
    chk(rd == 32'h5F, "R7 bit0=0 keeps flag", rd, 32'h5F);
    access(1'b1, 3'd1, 2'd0, 32'h01, rd, cyc, bok);
    access(1'b0, 3'd1, 2'd0, 0, rd, cyc, bok);
    chk(rd == 32'h5E, "R7 bit0=1 clears flag", rd, 32'h5E);

    // R6: silent peripheral timeout on a 2-byte write
    access(1'b1, 3'd2, 2'd0, 32'h04, rd, cyc, bok);
    hang = 1'b1;
    access(1'b1, 3'd4, 2'd1, 32'hABCD, rd, cyc, bok);
    chk(cyc == TMO + 1, "R6 timeout ack latency", cyc, TMO + 1);
    chk(nHs == 0, "R6 no completed handshake", nHs, 0);
    chk(rd == 32'hFFFF, "R4 write ack ones", rd, 32'hFFFF);
    hang = 1'b0;
    access(1'b0, 3'd1, 2'd0, 0, rd, cyc, bok);
    chk(rd == 32'h5F, "R6 flag set after timeout", rd, 32'h5F);

    // R9: reset clears flag and control
    pulseReset();
    access(1'b0, 3'd1, 2'd0, 0, rd, cyc, bok);
    chk(rd == 32'h5E, "R9 reset clears flag", rd, 32'h5E);
    chk(ctrlPins == 8'hCC, "R9 control after reset", ctrlPins, 8'hCC);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule